// File: doc/BRIEF.md
# Adaptive DRAM Page Policy Unit

This block keeps a table of which row, if any, is open in each DRAM bank, and decides for every read or write command that is about to issue whether auto-precharge should go with it. A memory controller presents the command (kind, bank, row) and the queued requests still waiting for that same bank. The block counts those requests, works out whether any of them targets the row that is open now, and applies one of four page policies. Two of them are fixed: the page is always left open, or it is always closed. The other two adapt to the queued traffic for the bank.

The decision is combinational in the cycle the command is presented. The open-row table is updated on the following clock edge. Activate opens a row. Precharge, precharge-all, and a read or write that carries auto-precharge close it. A second read port lets the controller see the state of any bank without side effects.

Top module: `page_policy_unit`

## Requirements
- R1: With policy code 0 (keep open), `ap_attach` is never high.
- R2: With policy code 2 (always close), every presented read (kind 2) or write (kind 3) has `ap_attach` high.
- R3: With policy code 1, a read or write gets auto-precharge only when `q_count` is at least one and `q_hit` is low.
- R4: With policy code 3, a read or write gets auto-precharge when `q_count` is zero or `q_hit` is low.
- R5: `q_count` is the number of set bits in `q_vld`. `q_hit` is high only when the command's bank is open and some entry `i` with `q_vld[i]` set holds, in `q_row[i*ROW_W +: ROW_W]`, that bank's open row. Entries whose valid bit is clear take no part.
- R6: An activate (kind 1) opens the bank at `cmd_bank` with row `cmd_row` from the next cycle on.
- R7: A precharge (kind 4) closes only the bank at `cmd_bank`. A precharge-all (kind 5) closes every bank. In both cases the change shows from the next cycle on.
- R8: A read or write that carries auto-precharge closes its bank from the next cycle on. One without auto-precharge leaves the bank open with its row unchanged.
- R9: `ap_attach` is low when `cmd_valid` is low or the kind is not a read or a write (no-op is kind 0).
- R10: A synchronous reset with `rst_n` low closes every bank.
- R11: `lk_open` and `lk_row` show the table entry of bank `lk_bank`. `lk_row` is meaningful only while `lk_open` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| policy_sel | input | 2 | Page policy: 0 open, 1 open-adaptive, 2 closed, 3 closed-adaptive |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 3 | 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all |
| cmd_bank | input | BANK_W | Target bank |
| cmd_row | input | ROW_W | Row opened by an activate |
| q_vld | input | QDEPTH | Valid bits of the queued requests for the target bank |
| q_row | input | QDEPTH*ROW_W | Rows of the queued requests, entry i at bits i*ROW_W upward |
| lk_bank | input | BANK_W | Bank to inspect |
| lk_open | output | 1 | Inspected bank has an open row |
| lk_row | output | ROW_W | Open row of the inspected bank |
| ap_attach | output | 1 | Attach auto-precharge to the presented read or write |
| q_count | output | CNT_W | Number of valid queued requests |
| q_hit | output | 1 | Some valid queued request hits the open row |

## Verification
The bench uses the default sizes: eight banks, 14-bit rows and four queue slots. Random rows are drawn from only four values, so queued entries match the open row often and the hit, miss and empty-queue cases of both adaptive policies all occur. The policy changes every cycle in the random phase, which mixes fixed and adaptive decisions on the same table contents. Directed steps cover the remaining cases: an entry matching a stale row of a closed bank, a matching entry whose valid bit is clear, precharge of one bank next to another open bank, and a reset in the middle of the run.

// File: rtl/ppu_pkg.sv
// Shared encodings for the page policy unit.
// Assumes: controller uses the same command and policy codes.
package ppu_pkg;
    typedef enum logic [1:0] {
        PG_OPEN        = 2'd0,
        PG_OPEN_ADPT   = 2'd1,
        PG_CLOSED      = 2'd2,
        PG_CLOSED_ADPT = 2'd3
    } pg_policy_e;

    typedef enum logic [2:0] {
        DC_NOP  = 3'd0,
        DC_ACT  = 3'd1,
        DC_RD   = 3'd2,
        DC_WR   = 3'd3,
        DC_PRE  = 3'd4,
        DC_PREA = 3'd5
    } dram_cmd_e;
endpackage

// File: rtl/ppu_open_row_table.sv
// Per-bank open-row table: valid bit and row index per bank.
// Assumes: set, clear and clear-all are never requested together.
module ppu_open_row_table #(
    parameter int NBANK  = 8,
    parameter int ROW_W  = 14,
    parameter int BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic              clr_all,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [BANK_W-1:0] rd_bank,
    output logic              rd_vld,
    output logic [ROW_W-1:0]  rd_row,
    input  logic [BANK_W-1:0] lk_bank,
    output logic              lk_vld,
    output logic [ROW_W-1:0]  lk_row
);
    logic [NBANK-1:0] vld_vec;
    logic [ROW_W-1:0] row_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Valid bit: reset/clear-all/clear drop it, activate sets it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                   vld_vec[b] <= 1'b0;
            else if (clr_all)                             vld_vec[b] <= 1'b0;
            else if (set_en && wr_bank == BANK_W'(b))     vld_vec[b] <= 1'b1;
            else if (clr_en && wr_bank == BANK_W'(b))     vld_vec[b] <= 1'b0;
        end
        // Row index: captured on activate, otherwise held.
        always_ff @(posedge clk) begin
            if (set_en && wr_bank == BANK_W'(b)) row_q[b] <= wr_row;
        end
    end

    // Read ports: command bank and inspection bank.
    always_comb begin
        rd_vld = vld_vec[rd_bank];
        rd_row = row_q[rd_bank];
        lk_vld = vld_vec[lk_bank];
        lk_row = row_q[lk_bank];
    end

    a_r6_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> vld_vec[$past(wr_bank)] && row_q[$past(wr_bank)] == $past(wr_row));
    a_r8_clear_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> !vld_vec[$past(wr_bank)]);
    a_r7_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> vld_vec == '0);
endmodule

// File: rtl/ppu_queue_scan.sv
// Summarises the queued requests of the target bank: count and row hit.
// Assumes: all presented entries belong to the command's bank.
module ppu_queue_scan #(
    parameter int QDEPTH = 4,
    parameter int ROW_W  = 14,
    parameter int CNT_W  = $clog2(QDEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [QDEPTH-1:0]       q_vld,
    input  logic [QDEPTH*ROW_W-1:0] q_row,
    input  logic                    open_vld,
    input  logic [ROW_W-1:0]        open_row,
    output logic [CNT_W-1:0]        cnt,
    output logic                    hit
);
    logic [QDEPTH-1:0] match;

    for (genvar i = 0; i < QDEPTH; i++) begin : g_ent
        assign match[i] = q_vld[i] && open_vld && (q_row[i*ROW_W +: ROW_W] == open_row);
    end

    // Population count of valid entries and hit reduction.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < QDEPTH; i++) cnt = cnt + CNT_W'(q_vld[i]);
        hit = |match;
    end

    a_r5_hit_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> open_vld && q_vld != '0);
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(QDEPTH));
endmodule

// File: rtl/ppu_decide.sv
// Policy mux: chooses auto-precharge for a read or write.
// Assumes: cnt/hit describe the command's bank in the same cycle.
module ppu_decide #(
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ppu_pkg::pg_policy_e policy,
    input  logic              rdwr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              hit,
    output logic              ap
);
    import ppu_pkg::*;

    // Decision per policy, gated by a read or write being presented.
    always_comb begin
        unique case (policy)
            PG_OPEN:        ap = 1'b0;
            PG_OPEN_ADPT:   ap = rdwr && (cnt != '0) && !hit;
            PG_CLOSED:      ap = rdwr;
            PG_CLOSED_ADPT: ap = rdwr && !hit;
            default:        ap = 1'b0;
        endcase
    end

    a_r1_open_never: assert property (@(posedge clk) disable iff (!rst_n)
        policy == PG_OPEN |-> !ap);
    a_r2_closed_always: assert property (@(posedge clk) disable iff (!rst_n)
        (rdwr && policy == PG_CLOSED) |-> ap);
    a_r3_oa_empty_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (policy == PG_OPEN_ADPT && cnt == '0) |-> !ap);
    a_r4_ca_empty_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (rdwr && policy == PG_CLOSED_ADPT && cnt == '0) |-> ap);
    a_r9_idle_no_ap: assert property (@(posedge clk) disable iff (!rst_n)
        !rdwr |-> !ap);
endmodule

// File: rtl/page_policy_unit.sv
// Top: open-row tracking plus per-command auto-precharge decision.
// Assumes: decision is used in the issue cycle; table updates on that edge.
module page_policy_unit #(
    parameter int NBANK  = 8,
    parameter int ROW_W  = 14,
    parameter int QDEPTH = 4,
    parameter int BANK_W = $clog2(NBANK),
    parameter int CNT_W  = $clog2(QDEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              policy_sel,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_kind,
    input  logic [BANK_W-1:0]       cmd_bank,
    input  logic [ROW_W-1:0]        cmd_row,
    input  logic [QDEPTH-1:0]       q_vld,
    input  logic [QDEPTH*ROW_W-1:0] q_row,
    input  logic [BANK_W-1:0]       lk_bank,
    output logic                    lk_open,
    output logic [ROW_W-1:0]        lk_row,
    output logic                    ap_attach,
    output logic [CNT_W-1:0]        q_count,
    output logic                    q_hit
);
    import ppu_pkg::*;

    dram_cmd_e        kind;
    logic             rdwr, set_en, clr_en, clr_all;
    logic             tgt_vld;
    logic [ROW_W-1:0] tgt_row;

    // Command decode.
    always_comb begin
        kind    = dram_cmd_e'(cmd_kind);
        rdwr    = cmd_valid && (kind == DC_RD || kind == DC_WR);
        set_en  = cmd_valid && kind == DC_ACT;
        clr_all = cmd_valid && kind == DC_PREA;
        clr_en  = (cmd_valid && kind == DC_PRE) || (rdwr && ap_attach);
    end

    ppu_open_row_table #(.NBANK(NBANK), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_en), .clr_en(clr_en), .clr_all(clr_all),
        .wr_bank(cmd_bank), .wr_row(cmd_row),
        .rd_bank(cmd_bank), .rd_vld(tgt_vld), .rd_row(tgt_row),
        .lk_bank(lk_bank), .lk_vld(lk_open), .lk_row(lk_row)
    );

    ppu_queue_scan #(.QDEPTH(QDEPTH), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_scan (
        .clk(clk), .rst_n(rst_n),
        .q_vld(q_vld), .q_row(q_row),
        .open_vld(tgt_vld), .open_row(tgt_row),
        .cnt(q_count), .hit(q_hit)
    );

    ppu_decide #(.CNT_W(CNT_W)) u_decide (
        .clk(clk), .rst_n(rst_n),
        .policy(pg_policy_e'(policy_sel)),
        .rdwr(rdwr), .cnt(q_count), .hit(q_hit),
        .ap(ap_attach)
    );
endmodule

// File: tb/page_policy_unit_tb.sv
module page_policy_unit_tb;
    localparam int NB = 8, RW = 14, QD = 4, BW = 3, CW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] policy_sel = '0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_kind = '0;
    logic [BW-1:0] cmd_bank = '0, lk_bank = '0;
    logic [RW-1:0] cmd_row = '0, lk_row;
    logic [QD-1:0] q_vld = '0;
    logic [QD*RW-1:0] q_row = '0;
    logic lk_open, ap_attach, q_hit;
    logic [CW-1:0] q_count;

    int checks = 0, failures = 0;
    bit m_open [NB];
    int m_row [NB];

    always #10 clk = ~clk;

    page_policy_unit u_dut (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One command cycle: drive, check outputs, then advance the model.
    task automatic step(int pol, bit v, int k, int b, int r, logic [QD-1:0] qv,
                        int r0, int r1, int r2, int r3, int lb, string tag);
        int rows [QD];
        int cnt, exp_ap;
        bit hit, rdwr;
        rows = '{r0, r1, r2, r3};
        @(negedge clk);
        policy_sel = 2'(pol); cmd_valid = v; cmd_kind = 3'(k);
        cmd_bank = BW'(b); cmd_row = RW'(r); q_vld = qv; lk_bank = BW'(lb);
        for (int i = 0; i < QD; i++) q_row[i*RW +: RW] = RW'(rows[i]);
        #2;
        cnt = 0; hit = 0;
        for (int i = 0; i < QD; i++) begin
            if (qv[i]) cnt++;
            if (qv[i] && m_open[b] && rows[i] == m_row[b]) hit = 1;
        end
        rdwr = v && (k == 2 || k == 3);
        case (pol)
            0: exp_ap = 0;
            1: exp_ap = (rdwr && cnt > 0 && !hit) ? 1 : 0;
            2: exp_ap = rdwr ? 1 : 0;
            default: exp_ap = (rdwr && (cnt == 0 || !hit)) ? 1 : 0;
        endcase
        chk({tag, " R5 count"}, int'(q_count), cnt);
        chk({tag, " R5 hit"}, int'(q_hit), int'(hit));
        chk({tag, " ap_attach"}, int'(ap_attach), exp_ap);
        chk({tag, " R11 lk_open"}, int'(lk_open), int'(m_open[lb]));
        if (m_open[lb]) chk({tag, " R11 lk_row"}, int'(lk_row), m_row[lb]);
        if (v) begin
            if (k == 1) begin m_open[b] = 1; m_row[b] = r; end
            else if (k == 4) m_open[b] = 0;
            else if (k == 5) for (int i = 0; i < NB; i++) m_open[i] = 0;
            else if (rdwr && exp_ap == 1) m_open[b] = 0;
        end
    endtask

    function automatic string ptag(int pol, bit v, int k);
        if (!(v && (k == 2 || k == 3))) return "R9";
        case (pol)
            0: return "R1";
            1: return "R3";
            2: return "R2";
            default: return "R4";
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R10: reset state, all banks closed
        for (int b = 0; b < NB; b++) step(0, 0, 0, 0, 0, '0, 0, 0, 0, 0, b, "R10");
        // R6: activate opens bank 2 row 5; R1 open policy keeps it
        step(0, 1, 1, 2, 5, '0, 0, 0, 0, 0, 2, "R6");
        step(0, 1, 2, 2, 0, 4'b0001, 7, 0, 0, 0, 2, "R1");
        step(0, 0, 0, 0, 0, '0, 0, 0, 0, 0, 2, "R8 kept");
        // R3: open-adaptive: empty -> keep, hit -> keep, all miss -> close
        step(1, 1, 3, 2, 0, '0, 0, 0, 0, 0, 2, "R3 empty");
        step(1, 1, 2, 2, 0, 4'b0011, 7, 5, 0, 0, 2, "R3 hit");
        step(1, 1, 2, 2, 0, 4'b0101, 7, 5, 9, 0, 2, "R3 miss");
        step(1, 0, 0, 0, 0, '0, 0, 0, 0, 0, 2, "R8 closed");
        // R5: stale row on closed bank is no hit; invalid slot ignored
        step(1, 1, 2, 2, 0, 4'b0001, 5, 0, 0, 0, 2, "R5 stale");
        step(1, 1, 1, 3, 6, '0, 0, 0, 0, 0, 3, "R6");
        step(3, 1, 2, 3, 0, 4'b0001, 1, 6, 0, 0, 3, "R5 invalid slot");
        // R4: closed-adaptive with empty queue closes
        step(1, 1, 1, 3, 6, '0, 0, 0, 0, 0, 3, "R6");
        step(3, 1, 2, 3, 0, 4'b1000, 0, 0, 0, 6, 3, "R4 hit keeps");
        step(3, 1, 3, 3, 0, '0, 0, 0, 0, 0, 3, "R4 empty");
        // R7: precharge one bank leaves the other; precharge-all clears
        step(0, 1, 1, 1, 11, '0, 0, 0, 0, 0, 1, "R6");
        step(0, 1, 1, 4, 12, '0, 0, 0, 0, 0, 4, "R6");
        step(0, 1, 4, 1, 0, '0, 0, 0, 0, 0, 4, "R7 pre");
        step(0, 0, 0, 0, 0, '0, 0, 0, 0, 0, 1, "R7 pre");
        step(0, 0, 0, 0, 0, '0, 0, 0, 0, 0, 4, "R7 other");
        step(2, 1, 4, 0, 0, '0, 0, 0, 0, 0, 4, "R9 pre");
        step(0, 1, 1, 6, 1, '0, 0, 0, 0, 0, 6, "R6");
        step(0, 1, 5, 0, 0, '0, 0, 0, 0, 0, 6, "R7 prea");
        for (int b = 0; b < NB; b++) step(0, 0, 0, 0, 0, '0, 0, 0, 0, 0, b, "R7 all");
        // R2: closed policy
        step(2, 1, 1, 5, 2, '0, 0, 0, 0, 0, 5, "R6");
        step(2, 1, 2, 5, 0, 4'b1111, 2, 2, 2, 2, 5, "R2");
        // Random phase against the model
        for (int n = 0; n < 4000; n++) begin
            int pol, k, b;
            bit v;
            pol = $urandom_range(0, 3);
            v = $urandom_range(0, 7) != 0;
            k = $urandom_range(0, 9);
            k = (k > 5) ? (k == 9 ? 1 : 2 + (k % 2)) : (k == 5 && $urandom_range(0, 3) != 0 ? 1 : k);
            b = $urandom_range(0, NB - 1);
            step(pol, v, k, b, $urandom_range(0, 3), 4'($urandom_range(0, 15)),
                 $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 3), $urandom_range(0, NB - 1), ptag(pol, v, k));
        end
        // R10: reset in mid-run closes open banks
        step(0, 1, 1, 7, 3, '0, 0, 0, 0, 0, 7, "R6");
        @(negedge clk) begin rst_n = 1'b0; cmd_valid = 1'b0; end
        @(posedge clk);
        for (int i = 0; i < NB; i++) m_open[i] = 0;
        @(negedge clk) rst_n = 1'b1;
        for (int b = 0; b < NB; b++) step(0, 0, 0, 0, 0, '0, 0, 0, 0, 0, b, "R10");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule